// File: doc/BRIEF.md
# Event Performance Monitor

This block counts hardware events and elapsed cycles for later inspection by software. It holds a parameterised bank of event counters, each tied to a fixed event number, and one wide cycle counter. Events arrive as an event number with a valid strobe, at most one event per cycle. Event counter k counts the events numbered k.

Software drives the block through a flat word-addressed register port with combinational read data. A global enable gates every counter. Three set/clear register pairs hold the per-counter enable, the overflow status and the interrupt enable. In each pair, bit 31 stands for the cycle counter and the low bits stand for the event counters.

The cycle counter runs only between a configurable start event and a configurable stop event. When both are set to the same number it runs freely. Any counter that wraps past all-ones latches its overflow bit. The interrupt output is raised while any overflow bit is latched and its interrupt enable is set.

Top module: `perf_monitor`

## Requirements
- R1: Register word addresses are: 0 control, 1 enable-set, 2 enable-clear, 3 overflow-set, 4 overflow-clear, 5 irq-enable-set, 6 irq-enable-clear, 7 cycle count low word, 8 cycle count upper bits, 9 cycle config, and 16+k event counter k. After reset every counter, enable, overflow and irq-enable bit is 0 and `irq` is low.
- R2: Control bit 0 is a read-write global enable. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 read as 0. Bits [15:11] read the number of event counters.
- R3: In the enable registers, writing 1 to bit k of the set register enables counter k, and writing 1 to bit k of the clear register disables it. Bit 31 stands for the cycle counter. Both registers read the current enable state, and bits of counters that do not exist read 0.
- R4: Event counter k adds one for each valid event numbered k, but only while both the global enable and its own enable are 1. Otherwise it holds its value.
- R5: A counter that steps from all-ones to zero sets its overflow bit (bit k, or bit 31 for the cycle counter). The overflow set and clear registers set and clear bits by mask. A wrap in the same cycle as a software clear leaves the bit set.
- R6: `irq` is high exactly when some counter has both its overflow bit and its irq-enable bit set. The irq-enable bits are set and cleared by mask like the enables.
- R7: Cycle config bits [9:0] select the start event and bits [25:16] select the stop event. When the two differ, the cycle counter counts the clock edges after the start event's edge up to and including the stop event's edge. It counts only while the global enable and enable bit 31 are 1.
- R8: When the start and stop numbers are equal, the cycle counter counts every clock edge while it is enabled.
- R9: The 48-bit cycle counter reads as a low 32-bit word and an upper 16-bit word. Each part loads on a write, and the low word carries into the upper word.
- R10: A write to a counter loads the written value and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| evt_valid | input | 1 | Event strobe |
| evt_num | input | EVT_W (10) | Number of the event this cycle |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with three event counters, 32-bit event counters and the full 48-bit cycle counter. With only three counters, every combination of global enable and per-counter enable can be swept, and each combination is checked against event bursts of distinct lengths on mapped and unmapped event numbers. Preloading counters to all-ones brings both the 32-bit and the 48-bit wraps within a few cycles. The start/stop window, the free-running mode and the carry between the cycle counter's two words are each checked against edge counts worked out by hand from the stimulus.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned CYC_BIT = 31;

   localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
   localparam logic [ADDR_W-1:0] A_EN_SET  = 5'd1;
   localparam logic [ADDR_W-1:0] A_EN_CLR  = 5'd2;
   localparam logic [ADDR_W-1:0] A_OV_SET  = 5'd3;
   localparam logic [ADDR_W-1:0] A_OV_CLR  = 5'd4;
   localparam logic [ADDR_W-1:0] A_IE_SET  = 5'd5;
   localparam logic [ADDR_W-1:0] A_IE_CLR  = 5'd6;
   localparam logic [ADDR_W-1:0] A_CYC_LO  = 5'd7;
   localparam logic [ADDR_W-1:0] A_CYC_HI  = 5'd8;
   localparam logic [ADDR_W-1:0] A_CYC_CFG = 5'd9;
   localparam logic [ADDR_W-1:0] A_EVT0    = 5'd16;

   localparam int unsigned CTRL_EN      = 0;
   localparam int unsigned CTRL_CLR_EVT = 1;
   localparam int unsigned CTRL_CLR_CYC = 2;
   localparam int unsigned CTRL_NCNT_LO = 11;
   localparam int unsigned CFG_STOP_LO  = 16;
endpackage

// File: rtl/pm_mask_reg.sv
module pm_mask_reg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] sw_set, sw_clr, q_n;

   always_comb begin
      sw_set = set_we ? wdata : '0;
      sw_clr = clr_we ? wdata : '0;
      // hardware set wins over a software clear in the same cycle
      q_n    = (((q | sw_set) & ~sw_clr) | hw_set) & IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_n;
   end

   AST_MASK_HWSET: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hw_set & IMPL)) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL))); // R5
endmodule

// File: rtl/pm_event_counter.sv
module pm_event_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             inc,
   output logic [CNT_W-1:0] q,
   output logic             wrap
);
   assign wrap = inc & ~clr & ~we & (&q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (we)  q <= wdata;
      else if (inc) q <= q + 1'b1;
   end

   AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !we && !clr) |=> (q == $past(q) + 1'b1)); // R4
   AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !we && !clr) |=> $stable(q)); // R4
   AST_EVT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> (q == $past(wdata))); // R10
endmodule

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter #(
   parameter int unsigned CYC_W = 48,
   parameter int unsigned EVT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             evt_valid,
   input  logic [EVT_W-1:0] evt_num,
   input  logic [EVT_W-1:0] start_num,
   input  logic [EVT_W-1:0] stop_num,
   input  logic             clr,
   input  logic             we_lo,
   input  logic             we_hi,
   input  logic [31:0]      wdata,
   output logic [CYC_W-1:0] q,
   output logic             wrap
);
   localparam int unsigned HI_W = CYC_W - 32;

   logic free_run, start_hit, stop_hit, run_q, counting;
   logic [CYC_W-1:0] q_n;

   assign free_run  = (start_num == stop_num);
   assign start_hit = evt_valid & (evt_num == start_num);
   assign stop_hit  = evt_valid & (evt_num == stop_num);
   assign counting  = run_en & (free_run | run_q);
   assign wrap      = counting & ~clr & ~we_lo & ~we_hi & (&q);

   // stop beats start; a matched pair leaves the window state untouched
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= 1'b0;
      else if (!free_run && stop_hit)  run_q <= 1'b0;
      else if (!free_run && start_hit) run_q <= 1'b1;
   end

   always_comb begin
      q_n = q;
      if (clr) q_n = '0;
      else if (we_lo || we_hi) begin
         if (we_lo) q_n[31:0]     = wdata;
         if (we_hi) q_n[CYC_W-1:32] = wdata[HI_W-1:0];
      end
      else if (counting) q_n = q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_n;
   end

   AST_CYC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!free_run && stop_hit) |=> !run_q); // R7
   AST_CYC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !clr && !we_lo && !we_hi) |=> $stable(q)); // R7
   AST_CYC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && free_run && !clr && !we_lo && !we_hi) |=> (q == $past(q) + 1'b1)); // R8
   AST_CYC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0)); // R2
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
   import pm_pkg::*;
#(
   parameter int unsigned NUM_CNT = 4,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned CYC_W   = 48,
   parameter int unsigned EVT_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              evt_valid,
   input  logic [EVT_W-1:0]  evt_num,
   output logic              irq
);
   localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_CNT) - 32'd1);
   localparam int unsigned HI_W = CYC_W - 32;

   if (NUM_CNT < 1 || NUM_CNT > 16) begin : g_bad_ncnt
      $error("perf_monitor: NUM_CNT must be 1..16");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cntw
      $error("perf_monitor: CNT_W must be 2..32");
   end
   if (CYC_W <= 32 || CYC_W > 64) begin : g_bad_cycw
      $error("perf_monitor: CYC_W must be 33..64");
   end
   if (EVT_W < 4 || EVT_W > 16) begin : g_bad_evtw
      $error("perf_monitor: EVT_W must be 4..16");
   end

   logic ge_q;
   logic [EVT_W-1:0] start_q, stop_q;
   logic [31:0] en_q, ov_q, ie_q, ov_hw;
   logic [CNT_W-1:0] cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0] evt_wrap;
   logic [CYC_W-1:0] cyc_q;
   logic cyc_wrap;
   logic clr_evt, clr_cyc;

   function automatic logic hit(input logic [4:0] a);
      return reg_we && (reg_addr == a);
   endfunction

   assign clr_evt = hit(A_CTRL) & reg_wdata[CTRL_CLR_EVT];
   assign clr_cyc = hit(A_CTRL) & reg_wdata[CTRL_CLR_CYC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ge_q    <= 1'b0;
         start_q <= '0;
         stop_q  <= '0;
      end else begin
         if (hit(A_CTRL)) ge_q <= reg_wdata[CTRL_EN];
         if (hit(A_CYC_CFG)) begin
            start_q <= reg_wdata[EVT_W-1:0];
            stop_q  <= reg_wdata[CFG_STOP_LO +: EVT_W];
         end
      end
   end

   pm_mask_reg #(.W(32), .IMPL(IMPL_MASK)) u_en (
      .clk(clk), .rst_n(rst_n), .set_we(hit(A_EN_SET)), .clr_we(hit(A_EN_CLR)),
      .wdata(reg_wdata), .hw_set(32'd0), .q(en_q));

   pm_mask_reg #(.W(32), .IMPL(IMPL_MASK)) u_ov (
      .clk(clk), .rst_n(rst_n), .set_we(hit(A_OV_SET)), .clr_we(hit(A_OV_CLR)),
      .wdata(reg_wdata), .hw_set(ov_hw), .q(ov_q));

   pm_mask_reg #(.W(32), .IMPL(IMPL_MASK)) u_ie (
      .clk(clk), .rst_n(rst_n), .set_we(hit(A_IE_SET)), .clr_we(hit(A_IE_CLR)),
      .wdata(reg_wdata), .hw_set(32'd0), .q(ie_q));

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_evt
      logic inc_k;
      assign inc_k = ge_q & en_q[k] & evt_valid & (evt_num == EVT_W'(k));
      pm_event_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(clr_evt),
         .we(hit(5'(int'(A_EVT0) + k))), .wdata(reg_wdata[CNT_W-1:0]),
         .inc(inc_k), .q(cnt_q[k]), .wrap(evt_wrap[k]));
   end

   pm_cycle_counter #(.CYC_W(CYC_W), .EVT_W(EVT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .run_en(ge_q & en_q[CYC_BIT]),
      .evt_valid(evt_valid), .evt_num(evt_num),
      .start_num(start_q), .stop_num(stop_q), .clr(clr_cyc),
      .we_lo(hit(A_CYC_LO)), .we_hi(hit(A_CYC_HI)), .wdata(reg_wdata),
      .q(cyc_q), .wrap(cyc_wrap));

   always_comb begin
      ov_hw = '0;
      ov_hw[CYC_BIT] = cyc_wrap;
      ov_hw[NUM_CNT-1:0] = evt_wrap;
   end

   assign irq = |(ov_q & ie_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[CTRL_EN] = ge_q;
            reg_rdata[CTRL_NCNT_LO +: 5] = 5'(NUM_CNT);
         end
         A_EN_SET, A_EN_CLR: reg_rdata = en_q;
         A_OV_SET, A_OV_CLR: reg_rdata = ov_q;
         A_IE_SET, A_IE_CLR: reg_rdata = ie_q;
         A_CYC_LO: reg_rdata = cyc_q[31:0];
         A_CYC_HI: reg_rdata[HI_W-1:0] = cyc_q[CYC_W-1:32];
         A_CYC_CFG: begin
            reg_rdata[EVT_W-1:0] = start_q;
            reg_rdata[CFG_STOP_LO +: EVT_W] = stop_q;
         end
         default: begin
            for (int k = 0; k < NUM_CNT; k++)
               if (reg_addr == 5'(int'(A_EVT0) + k)) reg_rdata[CNT_W-1:0] = cnt_q[k];
         end
      endcase
   end

   AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(ov_hw != 0) || $past(hit(A_OV_SET)) || $past(hit(A_IE_SET)))); // R6
   AST_GE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit(A_CTRL) |=> (ge_q == $past(reg_wdata[CTRL_EN]))); // R2
endmodule

// File: tb/sim_perf_monitor.sv
`timescale 1ns/1ps
module sim_perf_monitor;
   localparam int NCNT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] reg_addr = '0;
   logic reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic evt_valid = 1'b0;
   logic [9:0] evt_num = '0;
   logic irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   perf_monitor #(.NUM_CNT(NCNT), .CNT_W(32), .CYC_W(48), .EVT_W(10)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
      .evt_num(evt_num), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ev(input int n);
      @(negedge clk);
      evt_valid = 1'b1; evt_num = 10'(n);
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v1, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R2 counter-count field
      rchk("R2 ctrl reset", 5'd0, 32'h0000_1800);
      rchk("R1 enable reset", 5'd1, 32'h0);
      rchk("R1 overflow reset", 5'd3, 32'h0);
      rchk("R1 irq-en reset", 5'd5, 32'h0);
      rchk("R1 cycle reset", 5'd7, 32'h0);
      rchk("R1 event counter reset", 5'd16, 32'h0);
      check("R1 irq reset", {31'd0, irq}, 32'h0);

      // R2 write-only bits read 0
      wr(5'd0, 32'h7);
      rchk("R2 ctrl readback", 5'd0, 32'h0000_1801);
      wr(5'd0, 32'h0);
      rchk("R2 ctrl disable", 5'd0, 32'h0000_1800);

      // R3 enable set/clear
      wr(5'd1, 32'hFFFF_FFFF);
      rchk("R3 enable set read", 5'd1, 32'h8000_0007);
      rchk("R3 enable clr read", 5'd2, 32'h8000_0007);
      wr(5'd2, 32'h8000_0002);
      rchk("R3 enable partial clear", 5'd1, 32'h0000_0005);
      wr(5'd2, 32'hFFFF_FFFF);
      rchk("R3 enable all clear", 5'd2, 32'h0);

      // R4 sweep over global enable and every own-enable mask
      for (int ge = 0; ge < 2; ge++) begin
         for (int own = 0; own < 8; own++) begin
            wr(5'd0, 32'(ge) | 32'h2);
            wr(5'd2, 32'hFFFF_FFFF);
            wr(5'd1, 32'(own));
            for (int n = 0; n < 6; n++)
               for (int r = 0; r <= n; r++) ev(n);
            for (int k = 0; k < NCNT; k++) begin
               logic [31:0] exp;
               exp = (ge == 1 && own[k]) ? 32'(k + 1) : 32'h0;
               rchk($sformatf("R4 ge=%0d own=%0d cnt%0d", ge, own, k), 5'(16 + k), exp);
            end
         end
      end

      // R5 event counter wrap, R6 interrupt
      wr(5'd0, 32'h0);
      wr(5'd2, 32'hFFFF_FFFF);
      wr(5'd17, 32'hFFFF_FFFF);
      wr(5'd1, 32'h2);
      wr(5'd0, 32'h1);
      ev(1);
      rchk("R5 counter wraps to zero", 5'd17, 32'h0);
      rchk("R5 overflow bit set", 5'd3, 32'h2);
      #1 check("R6 irq masked", {31'd0, irq}, 32'h0);
      wr(5'd5, 32'h2);
      rchk("R6 irq-en read", 5'd5, 32'h2);
      #1 check("R6 irq raised", {31'd0, irq}, 32'h1);
      wr(5'd4, 32'h2);
      rchk("R5 overflow cleared", 5'd4, 32'h0);
      check("R6 irq dropped", {31'd0, irq}, 32'h0);

      // R5 wrap beats software clear in the same cycle
      wr(5'd17, 32'hFFFF_FFFF);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'd4; reg_wdata = 32'h2;
      evt_valid = 1'b1; evt_num = 10'd1;
      @(negedge clk);
      reg_we = 1'b0; evt_valid = 1'b0;
      rchk("R5 hw set beats sw clear", 5'd3, 32'h2);
      wr(5'd3, 32'hFFFF_FFFF);
      rchk("R5 sw set implemented bits", 5'd3, 32'h8000_0007);
      wr(5'd4, 32'hFFFF_FFFF);
      wr(5'd6, 32'hFFFF_FFFF);
      rchk("R5 sw clear all", 5'd3, 32'h0);

      // R10 write beats increment
      wr(5'd1, 32'h1);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = 32'h55;
      evt_valid = 1'b1; evt_num = 10'd0;
      @(negedge clk);
      reg_we = 1'b0; evt_valid = 1'b0;
      rchk("R10 write beats increment", 5'd16, 32'h55);

      // R7 start/stop window: start 5, stop 6
      wr(5'd1, 32'h8000_0000);
      wr(5'd9, (32'd6 << 16) | 32'd5);
      rchk("R7 config readback", 5'd9, 32'h0006_0005);
      wr(5'd0, 32'h5);
      repeat (4) @(negedge clk);
      rchk("R7 idle before start", 5'd7, 32'h0);
      ev(5);
      repeat (7) @(negedge clk);
      ev(6);
      rchk("R7 window count", 5'd7, 32'd9);
      repeat (3) @(negedge clk);
      ev(6);
      rchk("R7 held after stop", 5'd7, 32'd9);

      // R8 free running when start equals stop
      wr(5'd9, (32'd7 << 16) | 32'd7);
      wr(5'd0, 32'h5);
      repeat (10) @(negedge clk);
      rchk("R8 free-run count", 5'd7, 32'd11);
      wr(5'd0, 32'h0);
      rd(5'd7, v1);
      repeat (5) @(negedge clk);
      rd(5'd7, v2);
      check("R8 halts when globally disabled", v2, v1);

      // R9 two-word access and carry
      wr(5'd7, 32'hFFFF_FFFE);
      wr(5'd8, 32'h1);
      rchk("R9 load low", 5'd7, 32'hFFFF_FFFE);
      rchk("R9 load high", 5'd8, 32'h1);
      wr(5'd0, 32'h1);
      repeat (3) @(negedge clk);
      wr(5'd0, 32'h0);
      rchk("R9 carry low", 5'd7, 32'h3);
      rchk("R9 carry high", 5'd8, 32'h2);

      // R5/R9 cycle counter wrap
      wr(5'd7, 32'hFFFF_FFFF);
      wr(5'd8, 32'h0000_FFFF);
      wr(5'd0, 32'h1);
      wr(5'd0, 32'h0);
      rchk("R9 wrap low", 5'd7, 32'h1);
      rchk("R9 wrap high", 5'd8, 32'h0);
      rchk("R5 cycle overflow bit31", 5'd3, 32'h8000_0000);
      wr(5'd5, 32'h8000_0000);
      #1 check("R6 irq from cycle counter", {31'd0, irq}, 32'h1);

      // R2 reset bits
      wr(5'd0, 32'h2);
      rchk("R2 event counters cleared", 5'd16, 32'h0);
      rchk("R2 cycle untouched by event clear", 5'd7, 32'h1);
      wr(5'd0, 32'h4);
      rchk("R2 cycle counter cleared", 5'd7, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule